// File: doc/BRIEF.md
# String Move, Fill and Search Engine

This block is a multicycle sequencer that carries out block string operations against a simple single-port memory. A caller loads three working values (a destination or scan pointer, a source pointer or comparand, and an element count), picks an operation and pulses `start`. The engine then steps through memory one transaction at a time. When it finishes it returns the updated pointers, the remaining count and the carry and zero flags, and pulses `done`.

Seven operations share one pointer and count datapath. Each has its own end condition and its own flag rule. Operation codes on `op` are: 0 forward copy, 1 backward copy, 2 copy-until-NUL, 3 fill, 4 scan-until-equal, 5 scan-while-equal, 6 byte compare. Code 7 is reserved. Sizes on `size` are 0 byte, 1 halfword and 2 word; code 3 is illegal. Size is used only by fill and the two scans. Copies and compare always move bytes.

The memory port presents request, write enable, size, address and write data, and waits for `mem_ready`. Read data and write data are right-justified and little-endian. A loaded byte or halfword is zero-extended before it is compared.

The controller has five states:
- ST_IDLE waits for `start`.
- ST_FETCH_A performs the first read of a step. It reads the source for a copy and the R1 element for a scan or compare.
- ST_FETCH_B reads the second byte of a compare.
- ST_PUT performs the write of a copy or fill.
- ST_FINISH drives `done` for one cycle.

Transitions:
- ST_IDLE goes to ST_FINISH on an accepted start with a zero count, to ST_PUT for a fill, and to ST_FETCH_A otherwise. A rejected start stays in ST_IDLE.
- ST_FETCH_A goes to ST_PUT for a copy and to ST_FETCH_B for a compare. For a scan it goes to ST_FINISH on a stop and stays in ST_FETCH_A otherwise.
- ST_FETCH_B goes to ST_FINISH on a stop and to ST_FETCH_A otherwise.
- ST_PUT goes to ST_FINISH on a stop. Otherwise it goes back to ST_PUT for a fill and to ST_FETCH_A for a copy.
- ST_FINISH always returns to ST_IDLE.

Top module: `str_engine`

## Requirements
- R1: An accepted start with a count of zero makes no memory access. It raises `done` in the cycle after the start edge, returns the input values unchanged and leaves both flags unchanged.
- R2: Forward copy (op 0) and backward copy (op 1) read a byte at the source pointer and write it at the destination pointer. Each step decrements the count and moves both pointers by +1 (op 0) or -1 (op 1). The operation ends when the count reaches zero.
- R3: Copy-until-NUL (op 2) copies forward like op 0 and also ends right after it copies a zero byte.
- R4: Fill (op 3) writes the low 1, 2 or 4 bytes of the second register (size 0, 1, 2) little-endian at the destination. It advances the destination by 1, 2 or 4 per element until the count is zero.
- R5: Scan-until-equal (op 4) loads a zero-extended element at R1, advances R1 by the element size and decrements the count. It stops when the element equals R2 or the count reaches zero. Z is then set if the last element equals R2, and C is set if the last element is unsigned less than or equal to R2.
- R6: Scan-while-equal (op 5) steps like op 4 and stops at the first element that differs from R2, or when the count reaches zero. Z is set if the remaining count is zero, and C is set if the last element is unsigned less than or equal to R2.
- R7: Byte compare (op 6) reads a byte at R1 then a byte at R2, increments both pointers and decrements the count. It stops on a mismatch, when the R1 byte is zero, or when the count reaches zero. Z is set if the last two bytes are equal, and C is set if the R1 byte is unsigned greater than or equal to the R2 byte.
- R8: Op code 7, or size code 3 with op 3, 4 or 5, is rejected. `illegal` pulses in the cycle after the start edge, with no memory access and no `done`.
- R9: At most one memory transaction is outstanding. A request holds its address, size and write enable stable until `mem_ready` is seen.
- R10: Copy and fill operations never change the C and Z flags.
- R11: `done` lasts exactly one cycle, and `start` is ignored while the engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code |
| size | input | 2 | Element size code for fill and scans |
| r1_in | input | W | Destination or scan pointer |
| r2_in | input | W | Source pointer or comparand / fill value |
| r3_in | input | W | Element count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_size | output | 2 | Access size code |
| mem_addr | output | W | Byte address |
| mem_wdata | output | W | Right-justified write data |
| mem_rdata | input | W | Right-justified read data |
| mem_ready | input | 1 | Transaction completes this cycle |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| r1_out | output | W | Updated R1 |
| r2_out | output | W | Updated R2 |
| r3_out | output | W | Updated count |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
For a zero count or a rejected request, `done` or `illegal` is due in the cycle right after the start edge. The bench samples at the first falling edge after that edge and requires the pulse there. For all other operations the results are valid while `done` is high. The memory model answers each request after a random 0 to 2 cycle wait, so completion time varies. The bench therefore waits for `done`, then compares the registers, the flags and the whole memory image against its own step-by-step model. It then confirms one falling edge later that `done` has dropped.

// File: rtl/str_pkg.sv
package str_pkg;
    typedef enum logic [2:0] {
        OP_COPY_FWD   = 3'd0,
        OP_COPY_BWD   = 3'd1,
        OP_COPY_NUL   = 3'd2,
        OP_FILL       = 3'd3,
        OP_SCAN_UNTIL = 3'd4,
        OP_SCAN_WHILE = 3'd5,
        OP_BYTE_CMP   = 3'd6,
        OP_RSVD       = 3'd7
    } str_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_A, ST_FETCH_B, ST_PUT, ST_FINISH
    } str_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/str_elem.sv
// Zero-extends a loaded element by size code and compares it with a reference.
module str_elem #(
    parameter int W = 32
) (
    input  logic [1:0]   size,
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         le,
    output logic         ge,
    output logic         a_zero
);
    logic [W-1:0] a;

    always_comb begin
        unique case (size)
            2'd0:    a = {{(W-8){1'b0}}, a_raw[7:0]};
            2'd1:    a = {{(W-16){1'b0}}, a_raw[15:0]};
            default: a = a_raw;
        endcase
    end

    assign eq     = (a == b);
    assign le     = (a <= b);
    assign ge     = (a >= b);
    assign a_zero = (a == '0);
endmodule

// File: rtl/str_stride.sv
// Signed pointer step: +/- (1 << size).
module str_stride #(
    parameter int W = 32
) (
    input  logic [1:0]   size,
    input  logic         down,
    output logic [W-1:0] delta
);
    logic [W-1:0] mag;

    assign mag   = W'(1) << size;
    assign delta = down ? (~mag + W'(1)) : mag;
endmodule

// File: rtl/str_engine.sv
module str_engine
    import str_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [1:0]   size,
    input  logic [W-1:0] r1_in,
    input  logic [W-1:0] r2_in,
    input  logic [W-1:0] r3_in,
    output logic         mem_req,
    output logic         mem_we,
    output logic [1:0]   mem_size,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic         busy,
    output logic         done,
    output logic         illegal,
    output logic [W-1:0] r1_out,
    output logic [W-1:0] r2_out,
    output logic [W-1:0] r3_out,
    output logic         flag_c,
    output logic         flag_z
);
    str_state_e   st, st_nx;
    str_op_e      op_q, in_op;
    logic [1:0]   size_q;
    logic [W-1:0] r1, r2, r3;
    logic [7:0]   tmp;
    logic         cf, zf, ill_q;

    logic bad, in_sized, is_copy, is_fill, is_scan, is_cmp, last;
    logic scan_stop, cmp_stop, nul_stop;

    // Decode of the incoming request and the latched operation
    always_comb begin
        in_op    = str_op_e'(op);
        in_sized = (in_op == OP_FILL) || (in_op == OP_SCAN_UNTIL) || (in_op == OP_SCAN_WHILE);
        bad      = (in_op == OP_RSVD) || (in_sized && size == SZ_BAD);
        is_copy  = (op_q == OP_COPY_FWD) || (op_q == OP_COPY_BWD) || (op_q == OP_COPY_NUL);
        is_fill  = (op_q == OP_FILL);
        is_scan  = (op_q == OP_SCAN_UNTIL) || (op_q == OP_SCAN_WHILE);
        is_cmp   = (op_q == OP_BYTE_CMP);
        last     = (r3 == W'(1));
        nul_stop = (op_q == OP_COPY_NUL) && (tmp == 8'd0);
    end

    // Element compare: scan element vs R2, or compare byte pair
    logic [1:0]   el_size;
    logic [W-1:0] el_a, el_b;
    logic         el_eq, el_le, el_ge, el_azero;

    always_comb begin
        if (st == ST_FETCH_B) begin
            el_size = SZ_BYTE;
            el_a    = W'(tmp);
            el_b    = W'(mem_rdata[7:0]);
        end else begin
            el_size = size_q;
            el_a    = mem_rdata;
            el_b    = r2;
        end
    end

    str_elem #(.W(W)) elem_i (
        .size(el_size), .a_raw(el_a), .b(el_b),
        .eq(el_eq), .le(el_le), .ge(el_ge), .a_zero(el_azero)
    );

    assign scan_stop = (op_q == OP_SCAN_UNTIL) ? el_eq : !el_eq;
    assign cmp_stop  = !el_eq || el_azero;

    // Pointer step for copies, fill and scans
    logic [1:0]   step_size;
    logic [W-1:0] delta;

    assign step_size = (is_fill || is_scan) ? size_q : SZ_BYTE;

    str_stride #(.W(W)) stride_i (
        .size(step_size), .down(op_q == OP_COPY_BWD), .delta(delta)
    );

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (start && !bad) begin
                    if (r3_in == '0)          st_nx = ST_FINISH;
                    else if (in_op == OP_FILL) st_nx = ST_PUT;
                    else                       st_nx = ST_FETCH_A;
                end
            end
            ST_FETCH_A: begin
                if (mem_ready) begin
                    if (is_copy)     st_nx = ST_PUT;
                    else if (is_cmp) st_nx = ST_FETCH_B;
                    else             st_nx = (scan_stop || last) ? ST_FINISH : ST_FETCH_A;
                end
            end
            ST_FETCH_B: begin
                if (mem_ready) st_nx = (cmp_stop || last) ? ST_FINISH : ST_FETCH_A;
            end
            ST_PUT: begin
                if (mem_ready) begin
                    if (last || nul_stop) st_nx = ST_FINISH;
                    else                  st_nx = is_fill ? ST_PUT : ST_FETCH_A;
                end
            end
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Working registers and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1 <= '0; r2 <= '0; r3 <= '0;
            tmp <= '0; cf <= 1'b0; zf <= 1'b0; ill_q <= 1'b0;
            op_q <= OP_COPY_FWD; size_q <= SZ_BYTE;
        end else begin
            ill_q <= start && (st == ST_IDLE) && bad;
            unique case (st)
                ST_IDLE: begin
                    if (start && !bad) begin
                        r1 <= r1_in; r2 <= r2_in; r3 <= r3_in;
                        op_q <= in_op; size_q <= size;
                    end
                end
                ST_FETCH_A: begin
                    if (mem_ready) begin
                        tmp <= mem_rdata[7:0];
                        if (is_scan) begin
                            r1 <= r1 + delta;
                            r3 <= r3 - W'(1);
                            if (scan_stop || last) begin
                                zf <= (op_q == OP_SCAN_UNTIL) ? el_eq : last;
                                cf <= el_le;
                            end
                        end
                    end
                end
                ST_FETCH_B: begin
                    if (mem_ready) begin
                        r1 <= r1 + W'(1);
                        r2 <= r2 + W'(1);
                        r3 <= r3 - W'(1);
                        if (cmp_stop || last) begin
                            zf <= el_eq;
                            cf <= el_ge;
                        end
                    end
                end
                ST_PUT: begin
                    if (mem_ready) begin
                        r1 <= r1 + delta;
                        if (is_copy) r2 <= r2 + delta;
                        r3 <= r3 - W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_FINISH);
        illegal   = ill_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = SZ_BYTE;
        mem_addr  = r1;
        mem_wdata = W'(tmp);
        unique case (st)
            ST_FETCH_A: begin
                mem_req  = 1'b1;
                mem_addr = is_copy ? r2 : r1;
                mem_size = is_scan ? size_q : SZ_BYTE;
            end
            ST_FETCH_B: begin
                mem_req  = 1'b1;
                mem_addr = r2;
            end
            ST_PUT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_size  = is_fill ? size_q : SZ_BYTE;
                mem_wdata = is_fill ? r2 : W'(tmp);
            end
            default: ;
        endcase
        r1_out = r1;
        r2_out = r2;
        r3_out = r3;
        flag_c = cf;
        flag_z = zf;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy && !mem_req && !done);

    // R1
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && st == ST_IDLE && !bad && r3_in == '0 |=> done && !mem_req);

    // R10
    copy_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (is_copy || is_fill) |=> $stable(flag_c) && $stable(flag_z));
endmodule

// File: tb/str_engine_tb_top.sv
module str_engine_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [2:0]   op;
    logic [1:0]   size;
    logic [W-1:0] r1_in, r2_in, r3_in;
    logic         mem_req, mem_we;
    logic [1:0]   mem_size;
    logic [W-1:0] mem_addr, mem_wdata;
    logic [W-1:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;
    logic         busy, done, illegal;
    logic [W-1:0] r1_out, r2_out, r3_out;
    logic         flag_c, flag_z;

    always #5 clk = ~clk;

    str_engine #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .illegal(illegal),
        .r1_out(r1_out), .r2_out(r2_out), .r3_out(r3_out),
        .flag_c(flag_c), .flag_z(flag_z)
    );

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int lat = 0;
    int acc_cnt = 0;
    int checks = 0;
    int fails = 0;
    logic exp_c = 1'b0;
    logic exp_z = 1'b0;

    // Memory responder: random 0..2 cycle wait, little-endian
    always @(negedge clk) begin
        if (mem_req) begin
            if (lat == 0) begin
                mem_ready = 1'b1;
                mem_rdata = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                             mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
            end else begin
                lat = lat - 1;
                mem_ready = 1'b0;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            acc_cnt = acc_cnt + 1;
            if (mem_we)
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
            lat = $urandom % 3;
        end
    end

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(logic [31:0] a, int sz);
        logic [31:0] v = '0;
        for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = exp_mem[8'(a[7:0] + 8'(k))];
        return v;
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0, 1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model on exp_mem and the expected flags
    task automatic model(input int o, input int sz, input logic [31:0] a1, a2, a3,
                         output logic [31:0] e1, e2, e3, output logic ill);
        logic [31:0] x1 = a1, x2 = a2, x3 = a3, el, st;
        logic [7:0] t, ca, cb;
        logic stop;
        ill = (o == 7) || ((o == 3 || o == 4 || o == 5) && sz == 3);
        if (!ill && x3 != 0) begin
            case (o)
                0, 1, 2: begin
                    st = (o == 1) ? 32'hFFFF_FFFF : 32'd1;
                    do begin
                        t = exp_mem[x2[7:0]];
                        exp_mem[x1[7:0]] = t;
                        x1 += st; x2 += st; x3 -= 1;
                    end while (x3 != 0 && !(o == 2 && t == 0));
                end
                3: begin
                    while (x3 != 0) begin
                        for (int k = 0; k < (1 << sz); k++) exp_mem[8'(x1[7:0] + 8'(k))] = x2[8*k +: 8];
                        x1 += 32'(1 << sz); x3 -= 1;
                    end
                end
                4, 5: begin
                    do begin
                        el = mrd(x1, sz);
                        x1 += 32'(1 << sz); x3 -= 1;
                        stop = (o == 4) ? (el == x2) : (el != x2);
                    end while (!stop && x3 != 0);
                    exp_z = (o == 4) ? (el == x2) : (x3 == 0);
                    exp_c = (el <= x2);
                end
                default: begin
                    do begin
                        ca = exp_mem[x1[7:0]]; cb = exp_mem[x2[7:0]];
                        x1 += 1; x2 += 1; x3 -= 1;
                    end while (ca == cb && ca != 0 && x3 != 0);
                    exp_z = (ca == cb);
                    exp_c = (ca >= cb);
                end
            endcase
        end
        e1 = x1; e2 = x2; e3 = x3;
    endtask

    task automatic run_op(input int o, input int sz, input logic [31:0] a1, a2, a3, input bit poke);
        logic [31:0] e1, e2, e3;
        logic ill;
        int n = 0;
        int nm = 0;
        string tg = tag_of(o);
        string ftg = (o <= 3) ? "R10" : tg;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        model(o, sz, a1, a2, a3, e1, e2, e3, ill);
        if (a3 == 0 && !ill) ftg = "R1";
        @(negedge clk);
        acc_cnt = 0;
        start = 1'b1; op = 3'(o); size = 2'(sz);
        r1_in = a1; r2_in = a2; r3_in = a3;
        @(negedge clk);
        start = 1'b0;
        while (!done && !illegal && n < 300) begin
            if (poke && n == 1) begin
                start = 1'b1; op = 3'd3; size = 2'd0; r1_in = a1; r2_in = 32'hAA; r3_in = 32'd4;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (ill) begin
            chk("R8", "illegal pulse", 32'(illegal), 32'd1);
            chk("R8", "cycles to illegal", 32'(n), 32'd0);
            @(negedge clk);
            @(negedge clk);
            chk("R8", "done after reject", 32'(done), 32'd0);
            chk("R8", "accesses after reject", 32'(acc_cnt), 32'd0);
        end else begin
            chk(tg, "done seen", 32'(done), 32'd1);
            chk(tg, "r1_out", r1_out, e1);
            chk(tg, "r2_out", r2_out, e2);
            chk(tg, "r3_out", r3_out, e3);
            chk(ftg, "flag_c", 32'(flag_c), 32'(exp_c));
            chk(ftg, "flag_z", 32'(flag_z), 32'(exp_z));
            if (a3 == 0) begin
                chk("R1", "accesses for zero count", 32'(acc_cnt), 32'd0);
                chk("R1", "cycles to done", 32'(n), 32'd0);
            end
            for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) nm++;
            chk(poke ? "R11" : tg, "memory mismatches", 32'(nm), 32'd0);
            @(negedge clk);
            chk("R11", "done one cycle", 32'(done), 32'd0);
        end
    endtask

    task automatic scramble(int span);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom % span);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; op = '0; size = '0;
        r1_in = '0; r2_in = '0; r3_in = '0;
        scramble(4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("RST", "done", 32'(done), 32'd0);
        chk("RST", "busy", 32'(busy), 32'd0);
        chk("RST", "mem_req", 32'(mem_req), 32'd0);
        chk("RST", "flags", {30'd0, flag_c, flag_z}, 32'd0);

        // R1 zero count, R8 rejects
        run_op(0, 0, 32'h10, 32'h20, 32'd0, 1'b0);
        run_op(3, 3, 32'h10, 32'h20, 32'd4, 1'b0);
        run_op(7, 0, 32'h10, 32'h20, 32'd4, 1'b0);
        run_op(5, 3, 32'h10, 32'h1, 32'd4, 1'b0);
        // R2 and R11 (start while busy)
        run_op(0, 3, 32'h40, 32'h80, 32'd8, 1'b1);
        run_op(1, 0, 32'h47, 32'h87, 32'd6, 1'b0);
        run_op(1, 0, 32'h2, 32'hC1, 32'd5, 1'b0);
        // R3 with a zero at offset 3
        mem[8'h90] = 8'd5; mem[8'h91] = 8'd6; mem[8'h92] = 8'd7; mem[8'h93] = 8'd0;
        run_op(2, 0, 32'hA0, 32'h90, 32'd10, 1'b0);
        // R4 each size
        run_op(3, 0, 32'h30, 32'h1234_56C3, 32'd3, 1'b0);
        run_op(3, 1, 32'h31, 32'h1234_56C3, 32'd3, 1'b0);
        run_op(3, 2, 32'hFE, 32'hDEAD_BEEF, 32'd2, 1'b0);
        // R5, R6
        run_op(4, 1, 32'h30, 32'h56C3, 32'd6, 1'b0);
        run_op(4, 0, 32'h50, 32'h1FF, 32'd4, 1'b0);
        run_op(5, 2, 32'hFE, 32'hDEAD_BEEF, 32'd2, 1'b0);
        run_op(5, 2, 32'hFE, 32'hDEAD_BEEF, 32'd5, 1'b0);
        // R7 equal strings ending in NUL, and mismatch
        for (int i = 0; i < 4; i++) begin mem[8'(8'h60 + i)] = 8'(i + 1); mem[8'(8'h70 + i)] = 8'(i + 1); end
        mem[8'h64] = 8'd0; mem[8'h74] = 8'd0;
        run_op(6, 0, 32'h60, 32'h70, 32'd9, 1'b0);
        mem[8'h72] = 8'd9;
        run_op(6, 0, 32'h60, 32'h70, 32'd9, 1'b0);
        run_op(6, 0, 32'h60, 32'h70, 32'd2, 1'b0);

        for (int it = 0; it < 400; it++) begin
            int o = $urandom % 8;
            int sz = ($urandom % 8 == 0) ? 3 : ($urandom % 3);
            logic [31:0] a2 = (o == 4 || o == 5) ? 32'($urandom % 4) :
                              (o == 3) ? $urandom : 32'($urandom % 256);
            if (it % 25 == 0) scramble(4);
            run_op(o, sz, 32'($urandom % 256), a2, 32'($urandom % 11), 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule